// File: doc/BRIEF.md
# Buffer RAM Pattern Self-Test Engine

This block checks a packet-buffer RAM made of 16-bit words through a single-port memory interface. After a start request it runs four fixed passes in a set order. In each pass it first fills the whole buffer with a pattern. It then reads every word back and compares each one with the value it expects. Every word that does not match adds one to a fault counter. The counter keeps its value across all four passes and stops at its maximum value instead of wrapping.

The buffer size in bytes is a parameter. The block steps through the buffer one word per clock cycle, so the byte address goes up by 2 on each access. Reads have one cycle of latency: the word appears on `mem_rdata` in the cycle after the read strobe. A one-cycle `done` pulse marks the end of a run, and `fail` gives the pass or fail result.

Top module: `ram_pattern_bist`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `fail`, `mem_we`, `mem_re` and `fault_count` are all 0.
- R2: A `start` sampled high while `busy` is low begins a run. `busy` is high from the next cycle for exactly 8×WORDS+1 cycles, where WORDS = BUF_BYTES/2.
- R3: Each write phase and each read phase makes exactly WORDS accesses, one per cycle, at byte addresses 0, 2, 4 and so on in ascending order. `mem_we` and `mem_re` are never high in the same cycle.
- R4: The passes run in order 1, 2, 3, 4. Each pass writes the whole buffer before its first read, and reads the whole buffer before the next pass writes.
- R5: The write data is as follows. Pass 1 writes the byte address, truncated to 16 bits. Pass 2 writes the byte address XOR (BUF_BYTES−1), truncated to 16 bits. Pass 3 writes 0xAA55. Pass 4 writes 0x55AA.
- R6: The word returned one cycle after each read strobe is compared with that word's pattern. Each mismatch adds 1 to `fault_count`. The count accumulates over all four passes and is cleared only when a new run is accepted.
- R7: `fault_count` saturates at 2^CNT_W−1 and never wraps to a lower value.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a run. `fault_count` already holds its final value in that cycle. `fail` is high exactly when `fault_count` is nonzero.
- R9: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its length, and no extra accesses are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a test run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Fault count is nonzero |
| fault_count | output | CNT_W | Saturating count of mismatched words |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | $clog2(BUF_BYTES) | Byte address of the current word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_re` |

## Verification
A wrong pass or word index shows up at the memory port in the same cycle: the address or the write data moves off the expected sequence. A bench-side monitor catches this on the first wrong access. A fault in the compare pipeline or the counter stays hidden until `done`. It then shows up in `fault_count` as a count that differs from what the injected faults predict. A single XOR fault on one word, a stuck-high data bus, and a clean buffer each set a different expected total. A fault in the sequencing shows up as a change in how long `busy` stays high, or in the cycle in which `done` is seen.

// File: rtl/ram_pattern_bist.sv
module ram_pattern_bist #(
  parameter int BUF_BYTES = 65536,
  parameter int CNT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic                         fail,
  output logic [CNT_W-1:0]             fault_count,
  output logic                         mem_we,
  output logic                         mem_re,
  output logic [$clog2(BUF_BYTES)-1:0] mem_addr,
  output logic [15:0]                  mem_wdata,
  input  logic [15:0]                  mem_rdata
);
  localparam int WORDS = BUF_BYTES / 2;
  localparam int AW    = $clog2(BUF_BYTES);
  localparam int IW    = AW - 1;
  localparam logic [IW-1:0]    LAST    = IW'(WORDS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [15:0]      MASK16  = 16'(BUF_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_FLUSH} state_t;

  state_t           state;
  logic [1:0]       pass_q;
  logic [IW-1:0]    idx_q;
  logic             chk_q;
  logic [15:0]      exp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  function automatic logic [15:0] pat_of(input logic [1:0] p, input logic [IW-1:0] i);
    logic [15:0] ba;
    ba = 16'({i, 1'b0});
    case (p)
      2'd0:    return ba;
      2'd1:    return ba ^ MASK16;
      2'd2:    return 16'hAA55;
      default: return 16'h55AA;
    endcase
  endfunction

  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign fault_count = cnt_q;
  assign fail        = |cnt_q;
  assign mem_we      = (state == S_WR);
  assign mem_re      = (state == S_RD);
  assign mem_addr    = {idx_q, 1'b0};
  assign mem_wdata   = pat_of(pass_q, idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pass_q <= '0;
      idx_q  <= '0;
      chk_q  <= 1'b0;
      exp_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      chk_q  <= (state == S_RD);
      exp_q  <= pat_of(pass_q, idx_q);
      if (chk_q && (mem_rdata != exp_q) && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_WR;
          pass_q <= '0;
          idx_q  <= '0;
          cnt_q  <= '0;
        end
        S_WR: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) begin
            idx_q <= '0;
            state <= S_RD;
          end
        end
        S_RD: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) begin
            idx_q <= '0;
            if (pass_q == 2'd3) state <= S_FLUSH;
            else begin
              pass_q <= pass_q + 1'b1;
              state  <= S_WR;
            end
          end
        end
        S_FLUSH: begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: single-port memory, never both strobes
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R3: addresses within a phase advance by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(2)));

  // R2: accepted start launches the first write at address 0
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_we && mem_addr == '0));

  // R6: count never decreases while a run is in progress
  a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (fault_count >= $past(fault_count)));

  // R7: saturated count holds unless a new run clears it
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_count == CNT_MAX && !(start && !busy)) |=> (fault_count == CNT_MAX));

  // R8: done is a single-cycle pulse outside busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R8: fail follows the count
  a_r8_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fail == (fault_count != '0));
endmodule

// File: tb/tb_ram_pattern_bist.sv
module tb_ram_pattern_bist;
  localparam int BUF_BYTES = 256;
  localparam int CNT_W     = 8;
  localparam int N         = BUF_BYTES / 2;
  localparam int AW        = $clog2(BUF_BYTES);
  localparam int CMAX      = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, fail, mem_we, mem_re;
  logic [CNT_W-1:0] fault_count;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  ram_pattern_bist #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fault_count(fault_count), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  int errors = 0;
  int checks = 0;

  // memory model with fault injection
  logic [15:0] mem [N];
  int          inj_word = -1;
  logic [15:0] inj_xor  = 16'h0;
  logic [15:0] stuck_or = 16'h0;
  initial for (int i = 0; i < N; i++) mem[i] = 16'h0;

  always @(posedge clk) begin
    if (mem_we)
      mem[mem_addr >> 1] <= (mem_wdata ^ (int'(mem_addr >> 1) == inj_word ? inj_xor : 16'h0)) | stuck_or;
    if (mem_re) mem_rdata <= mem[mem_addr >> 1];
  end

  function automatic logic [15:0] pat(input int p, input int w);
    logic [15:0] ba;
    ba = 16'(2 * w);
    case (p)
      0: return ba;
      1: return ba ^ 16'(BUF_BYTES - 1);
      2: return 16'hAA55;
      default: return 16'h55AA;
    endcase
  endfunction

  // access-sequence monitor
  int wr_n = 0, rd_n = 0, mon_err = 0, both_n = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_we && mem_re) both_n++;
      if (mem_we) begin
        if (int'(mem_addr) != 2 * (wr_n % N) || mem_wdata != pat(wr_n / N, wr_n % N) ||
            rd_n != (wr_n / N) * N) mon_err++;
        wr_n++;
      end
      if (mem_re) begin
        if (int'(mem_addr) != 2 * (rd_n % N) || wr_n != (rd_n / N + 1) * N) mon_err++;
        rd_n++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expected_faults();
    int c = 0;
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < N; w++) begin
        logic [15:0] s;
        s = (pat(p, w) ^ (w == inj_word ? inj_xor : 16'h0)) | stuck_or;
        if (s != pat(p, w) && c < CMAX) c++;
      end
    return c;
  endfunction

  // runs one test; extra_start pulses start mid-run
  task automatic run(input bit extra_start, output int len);
    int i;
    wr_n = 0; rd_n = 0; mon_err = 0; both_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    i = 0;
    while (!done && i < 20 * N) begin
      if (!busy) begin
        errors++; checks++;
        $display("FAIL R2: busy low at cycle %0d before done", i);
        i = 20 * N;
        break;
      end
      if (extra_start && i == 3 * N) start = 1'b1;
      if (extra_start && i == 3 * N + 4) start = 1'b0;
      @(negedge clk); i++;
    end
    len = i;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 count", fault_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes", {mem_we, mem_re}, 0);
    check("R1 fail", fail, 0);
  endtask

  task automatic t_clean();
    int len;
    inj_word = -1; inj_xor = 0; stuck_or = 0;
    run(0, len);
    check("R2 run length", len, 8 * N + 1);
    check("R8 done with busy low", {done, busy}, 2);
    check("R3 R4 R5 sequence errors", mon_err, 0);
    check("R3 simultaneous strobes", both_n, 0);
    check("R4 total writes", wr_n, 4 * N);
    check("R4 total reads", rd_n, 4 * N);
    check("R6 clean count", fault_count, 0);
    check("R8 fail clean", fail, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
  endtask

  task automatic t_single_fault();
    int len;
    inj_word = 37; inj_xor = 16'h0100; stuck_or = 0;
    run(0, len);
    check("R6 single-word fault over four passes", fault_count, expected_faults());
    check("R6 expected four", fault_count, 4);
    check("R8 fail set", fail, 1);
    @(negedge clk);
  endtask

  task automatic t_saturate();
    int len;
    inj_word = -1; inj_xor = 0; stuck_or = 16'hFFFF;
    run(0, len);
    check("R7 saturated count", fault_count, CMAX);
    check("R7 bench model", expected_faults(), CMAX);
    @(negedge clk);
  endtask

  task automatic t_rerun_clears();
    int len;
    inj_word = -1; inj_xor = 0; stuck_or = 0;
    @(negedge clk);
    check("R6 count held between runs", fault_count, CMAX);
    run(0, len);
    check("R6 cleared by new run", fault_count, 0);
    check("R8 fail cleared", fail, 0);
    @(negedge clk);
  endtask

  task automatic t_start_busy();
    int len;
    inj_word = 5; inj_xor = 16'h8001; stuck_or = 0;
    run(1, len);
    check("R9 length unchanged", len, 8 * N + 1);
    check("R9 no extra writes", wr_n, 4 * N);
    check("R9 no extra reads", rd_n, 4 * N);
    check("R9 count not cleared", fault_count, expected_faults());
    check("R9 sequence intact", mon_err, 0);
    @(negedge clk);
    check("R9 no restart", busy, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_single_fault();
    t_saturate();
    t_rerun_clears();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule